// File: doc/BRIEF.md
# System Control Register File

This block holds the privileged control registers of a processor core. Software reaches them through a 5-bit register number and a 3-bit select. Every register has its own write policy. On a write, some bits take the new value, some keep their old value, and the rest always read as zero. This lets the core write a whole word without disturbing fields that hardware owns.

Besides storage, the block decides when a control-register write must raise a pending hardware interrupt.
- A status write that turns the global interrupt enable on can raise the request.
- A cause write that sets a software interrupt bit can raise the request.
- Either write raises it only if a pending source is unmasked and the core is not in exception, error or debug mode.
- A status write that turns the enable off withdraws the request.

External interrupt lines are sampled into the cause register on every cycle. Accesses that use a select the register does not support are flagged and have no effect.

Top module: `sysctl_regfile`

## Requirements
- R1: A nonzero select is accepted only for register numbers 16 and 28. Any other register number with a nonzero select is a reserved access. Register 16 returns configuration word 0 for select 0 and configuration word 1 for select 1. Other selects of register 16, every select of register 28, and unimplemented register numbers read as zero and ignore writes.
- R2: Index register (number 0): a write updates only bits 3:0, bit 31 keeps its value, and every other bit reads as zero.
- R3: Both entry-low registers (numbers 2 and 3) store only bits 29:0 of the write data; bits 31:30 read as zero.
- R4: Context register (number 4): bits 31:24 keep their value (reset value given by parameter `CTX_HI_RST`), bits 23:4 take the write data, and bits 3:0 read as zero.
- R5: Page-mask (number 5) keeps only bits 24:13 of the write data. Wired (number 6) keeps only bits 3:0. Entry-high (number 10) stores the write data ANDed with 0xFFFFF0FF.
- R6: Status (number 12) stores the write data ANDed with 0xFA78FF01. Write-data bits 1 (exception level), 2 (error level) and 4 (user mode) are held as mode flags and read back in those bit positions. Bit 0 is the interrupt enable and bits 15:8 are the interrupt mask.
- R7: Cause (number 13): a write changes only bits 23, 22, 9 and 8; the bits under 0xB000F87C keep their value. Bits 15:10 follow `irq_hw_i[5:0]` one clock later, and this overrides any write.
- R8: A reserved access reads as zero and leaves every register unchanged. It drives `rsvd_o` high for exactly the one cycle after the access.
- R9: `irq_req_o` is set by a status write when all of these hold:
  - the write sets bit 0 while the stored bit 0 was clear;
  - write-data bits 1 and 2 are clear;
  - `dbg_mode_i` is low;
  - write-data bits 15:8 AND cause bits 15:8 is nonzero.
- R10: A status write that clears bit 0 while the stored bit 0 was set clears `irq_req_o`. No other event clears it.
- R11: `irq_req_o` is set by a cause write when all of these hold:
  - the write turns bit 8 or 9 from 0 to 1, and the matching status mask bit is set;
  - status bit 0 is set;
  - both mode flags from R6 (exception level and error level) are clear;
  - `dbg_mode_i` is low.
- R12: A read of the load-linked address register (number 17) returns the stored word shifted right by 4.
- R13: `rdata_o` is registered. It shows the addressed register one clock after `rd_i` and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_i | input | 1 | Read strobe |
| we_i | input | 1 | Write strobe |
| reg_num_i | input | 5 | Register number |
| sel_i | input | 3 | Register select |
| wdata_i | input | 32 | Write data |
| irq_hw_i | input | 6 | External interrupt lines into cause bits 15:10 |
| dbg_mode_i | input | 1 | Core is in debug mode |
| rdata_o | output | 32 | Registered read data |
| rsvd_o | output | 1 | One-cycle reserved-access pulse |
| irq_req_o | output | 1 | Hardware interrupt request |

## Verification
Results become visible after one clock edge:
- register contents, `irq_req_o` and `rsvd_o` change on the edge that samples the write or access;
- `rdata_o` changes on the edge that samples `rd_i`;
- a change on `irq_hw_i` reaches the cause register one edge later.

The bench drives each access on a falling edge and removes it on the next falling edge. It samples the outputs at that same falling edge, which is half a cycle after the result is due. It waits one more falling edge to confirm that `rsvd_o` has dropped. After changing the external lines, it lets two falling edges pass before it relies on the cause value.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int XLEN   = 32;
  localparam int REG_W  = 5;
  localparam int SEL_W  = 3;
  localparam int HWIRQ_N = 6;
  localparam int CFG_N  = 2;

  typedef enum logic [3:0] {
    RID_NONE, RID_INDEX, RID_ELO0, RID_ELO1, RID_CTX, RID_PMASK,
    RID_WIRED, RID_EHI, RID_STAT, RID_CAUSE, RID_CFG, RID_LLA
  } reg_id_e;

  // keep / writable masks per register
  localparam logic [XLEN-1:0] IDX_KEEP   = 32'h8000_0000;
  localparam logic [XLEN-1:0] IDX_WR     = 32'h0000_000F;
  localparam logic [XLEN-1:0] ELO_WR     = 32'h3FFF_FFFF;
  localparam logic [XLEN-1:0] CTX_KEEP   = 32'hFF00_0000;
  localparam logic [XLEN-1:0] CTX_WR     = 32'h00FF_FFF0;
  localparam logic [XLEN-1:0] PMASK_WR   = 32'h01FF_E000;
  localparam logic [XLEN-1:0] WIRED_WR   = 32'h0000_000F;
  localparam logic [XLEN-1:0] EHI_WR     = 32'hFFFF_F0FF;
  localparam logic [XLEN-1:0] STAT_WR    = 32'hFA78_FF01;
  localparam logic [XLEN-1:0] CAUSE_KEEP = 32'hB000_F87C;
  localparam logic [XLEN-1:0] CAUSE_WR   = 32'h00C0_0300;

  localparam int IE_BIT  = 0;
  localparam int EXL_BIT = 1;
  localparam int ERL_BIT = 2;
  localparam int UM_BIT  = 4;
  localparam int IM_LO   = 8;
  localparam int IM_HI   = 15;
  localparam int HW_LO   = 10;
  localparam int LLA_SHIFT = 4;

  typedef struct packed {
    logic um;
    logic erl;
    logic exl;
  } mode_t;
endpackage

// File: rtl/sysctl_addr_dec.sv
module sysctl_addr_dec
  import sysctl_pkg::*;
(
  input  logic [REG_W-1:0] reg_num_i,
  input  logic [SEL_W-1:0] sel_i,
  output reg_id_e          id_o,
  output logic             rsvd_o
);
  logic sel_ok;

  always_comb begin
    sel_ok = (sel_i == '0) || (reg_num_i == REG_W'(16)) || (reg_num_i == REG_W'(28));
    rsvd_o = !sel_ok;
    id_o   = RID_NONE;
    if (sel_ok) begin
      case (reg_num_i)
        REG_W'(0):  id_o = RID_INDEX;
        REG_W'(2):  id_o = RID_ELO0;
        REG_W'(3):  id_o = RID_ELO1;
        REG_W'(4):  id_o = RID_CTX;
        REG_W'(5):  id_o = RID_PMASK;
        REG_W'(6):  id_o = RID_WIRED;
        REG_W'(10): id_o = RID_EHI;
        REG_W'(12): id_o = RID_STAT;
        REG_W'(13): id_o = RID_CAUSE;
        REG_W'(16): id_o = RID_CFG;
        REG_W'(17): id_o = RID_LLA;
        default:    id_o = RID_NONE;
      endcase
    end
  end
endmodule

// File: rtl/sysctl_reg_bank.sv
module sysctl_reg_bank
  import sysctl_pkg::*;
#(
  parameter logic [7:0]      CTX_HI_RST = 8'hA5,
  parameter logic [XLEN-1:0] CFG0_VAL   = 32'h8000_0482,
  parameter logic [XLEN-1:0] CFG1_VAL   = 32'h1E19_0C8A
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  reg_id_e            id_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [XLEN-1:0]    wdata_i,
  input  logic [HWIRQ_N-1:0] irq_hw_i,
  output logic [XLEN-1:0]    rdata_o,
  output logic [XLEN-1:0]    status_o,
  output logic [XLEN-1:0]    cause_o,
  output mode_t              mode_o
);
  logic [XLEN-1:0] index_q, elo0_q, elo1_q, ctx_q, pmask_q, wired_q;
  logic [XLEN-1:0] ehi_q, stat_q, cause_q, lla_q, rdata_q;
  mode_t           mode_q;
  logic [XLEN-1:0] cfg_word [CFG_N];
  logic [XLEN-1:0] rd_mux, stat_view;

  generate
    for (genvar g = 0; g < CFG_N; g++) begin : g_cfg
      assign cfg_word[g] = (g == 0) ? CFG0_VAL : CFG1_VAL;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      index_q <= '0;
      elo0_q  <= '0;
      elo1_q  <= '0;
      ctx_q   <= {CTX_HI_RST, 24'h0};
      pmask_q <= '0;
      wired_q <= '0;
      ehi_q   <= '0;
      stat_q  <= '0;
      cause_q <= '0;
      lla_q   <= '0;
      mode_q  <= '0;
    end else begin
      if (wr_en_i) begin
        case (id_i)
          RID_INDEX: index_q <= (index_q & IDX_KEEP) | (wdata_i & IDX_WR);
          RID_ELO0:  elo0_q  <= wdata_i & ELO_WR;
          RID_ELO1:  elo1_q  <= wdata_i & ELO_WR;
          RID_CTX:   ctx_q   <= (ctx_q & CTX_KEEP) | (wdata_i & CTX_WR);
          RID_PMASK: pmask_q <= wdata_i & PMASK_WR;
          RID_WIRED: wired_q <= wdata_i & WIRED_WR;
          RID_EHI:   ehi_q   <= wdata_i & EHI_WR;
          RID_STAT: begin
            stat_q <= wdata_i & STAT_WR;
            mode_q <= '{um: wdata_i[UM_BIT], erl: wdata_i[ERL_BIT], exl: wdata_i[EXL_BIT]};
          end
          RID_CAUSE: cause_q <= (cause_q & CAUSE_KEEP) | (wdata_i & CAUSE_WR);
          RID_LLA:   lla_q   <= wdata_i;
          default: ;
        endcase
      end
      // external lines override any write to their field
      cause_q[HW_LO +: HWIRQ_N] <= irq_hw_i;
    end
  end

  always_comb begin
    stat_view = stat_q;
    stat_view[UM_BIT]  = mode_q.um;
    stat_view[ERL_BIT] = mode_q.erl;
    stat_view[EXL_BIT] = mode_q.exl;
    case (id_i)
      RID_INDEX: rd_mux = index_q;
      RID_ELO0:  rd_mux = elo0_q;
      RID_ELO1:  rd_mux = elo1_q;
      RID_CTX:   rd_mux = ctx_q;
      RID_PMASK: rd_mux = pmask_q;
      RID_WIRED: rd_mux = wired_q;
      RID_EHI:   rd_mux = ehi_q;
      RID_STAT:  rd_mux = stat_view;
      RID_CAUSE: rd_mux = cause_q;
      RID_CFG:   rd_mux = (32'(sel_i) < CFG_N) ? cfg_word[sel_i[0]] : '0;
      RID_LLA:   rd_mux = lla_q >> LLA_SHIFT;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign rdata_o  = rdata_q;
  assign status_o = stat_q;
  assign cause_o  = cause_q;
  assign mode_o   = mode_q;

  p_index_keep_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && id_i == RID_INDEX) |=> (index_q[31] == $past(index_q[31])));

  p_ctx_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && id_i == RID_CTX) |=> (ctx_q[31:24] == $past(ctx_q[31:24])));

  p_rd_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: rtl/sysctl_irq_ctl.sv
module sysctl_irq_ctl
  import sysctl_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            stat_wr_i,
  input  logic            cause_wr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [XLEN-1:0] status_i,
  input  logic [XLEN-1:0] cause_i,
  input  mode_t           mode_i,
  input  logic            dbg_mode_i,
  output logic            irq_req_o
);
  logic irq_q, stat_raise, stat_drop, sw_raise;
  logic [1:0] sw_new;

  always_comb begin
    // status write: new mode flags come from the write data
    stat_raise = stat_wr_i && wdata_i[IE_BIT] && !status_i[IE_BIT]
              && !wdata_i[EXL_BIT] && !wdata_i[ERL_BIT] && !dbg_mode_i
              && |(wdata_i[IM_HI:IM_LO] & cause_i[IM_HI:IM_LO]);
    stat_drop  = stat_wr_i && !wdata_i[IE_BIT] && status_i[IE_BIT];
    sw_new     = wdata_i[9:8] & ~cause_i[9:8];
    sw_raise   = cause_wr_i && |(sw_new & status_i[9:8]) && status_i[IE_BIT]
              && !mode_i.exl && !mode_i.erl && !dbg_mode_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      irq_q <= 1'b0;
    else if (stat_raise || sw_raise)  irq_q <= 1'b1;
    else if (stat_drop)               irq_q <= 1'b0;
  end

  assign irq_req_o = irq_q;

  p_irq_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(stat_wr_i || cause_wr_i));

  p_irq_fall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_q) |-> $past(stat_wr_i && !wdata_i[IE_BIT]));
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter logic [7:0]      CTX_HI_RST = 8'hA5,
  parameter logic [XLEN-1:0] CFG0_VAL   = 32'h8000_0482,
  parameter logic [XLEN-1:0] CFG1_VAL   = 32'h1E19_0C8A
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_i,
  input  logic               we_i,
  input  logic [REG_W-1:0]   reg_num_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [XLEN-1:0]    wdata_i,
  input  logic [HWIRQ_N-1:0] irq_hw_i,
  input  logic               dbg_mode_i,
  output logic [XLEN-1:0]    rdata_o,
  output logic               rsvd_o,
  output logic               irq_req_o
);
  reg_id_e         dec_id;
  logic            dec_rsvd, wr_en, rsvd_q;
  logic [XLEN-1:0] stat_w, cause_w;
  mode_t           mode_w;

  sysctl_addr_dec u_dec (
    .reg_num_i (reg_num_i),
    .sel_i     (sel_i),
    .id_o      (dec_id),
    .rsvd_o    (dec_rsvd)
  );

  assign wr_en = we_i && !dec_rsvd;

  sysctl_reg_bank #(
    .CTX_HI_RST (CTX_HI_RST),
    .CFG0_VAL   (CFG0_VAL),
    .CFG1_VAL   (CFG1_VAL)
  ) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .rd_en_i  (rd_i),
    .id_i     (dec_id),
    .sel_i    (sel_i),
    .wdata_i  (wdata_i),
    .irq_hw_i (irq_hw_i),
    .rdata_o  (rdata_o),
    .status_o (stat_w),
    .cause_o  (cause_w),
    .mode_o   (mode_w)
  );

  sysctl_irq_ctl u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stat_wr_i  (wr_en && dec_id == RID_STAT),
    .cause_wr_i (wr_en && dec_id == RID_CAUSE),
    .wdata_i    (wdata_i),
    .status_i   (stat_w),
    .cause_i    (cause_w),
    .mode_i     (mode_w),
    .dbg_mode_i (dbg_mode_i),
    .irq_req_o  (irq_req_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsvd_q <= 1'b0;
    else         rsvd_q <= (rd_i || we_i) && dec_rsvd;
  end

  assign rsvd_o = rsvd_q;

  p_rsvd_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsvd_o |-> $past(rd_i || we_i));

  p_rsvd_nowr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && dec_rsvd) |=> ($stable(stat_w) && $stable(mode_w)));
endmodule

// File: tb/sysctl_regfile_tb_top.sv
`timescale 1ns/1ps
module sysctl_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd = 1'b0, we = 1'b0, dbg = 1'b0;
  logic [4:0]  rnum = '0;
  logic [2:0]  sel = '0;
  logic [31:0] wdata = '0;
  logic [5:0]  hw = '0;
  logic [31:0] rdata;
  logic        rsvd, irq;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  sysctl_regfile dut_i (
    .clk_i (clk), .rst_ni (rst_n), .rd_i (rd), .we_i (we),
    .reg_num_i (rnum), .sel_i (sel), .wdata_i (wdata), .irq_hw_i (hw),
    .dbg_mode_i (dbg), .rdata_o (rdata), .rsvd_o (rsvd), .irq_req_o (irq)
  );

  // {reg, sel, write data, expected read}
  localparam int NV = 11;
  localparam logic [71:0] VEC [NV] = '{
    {5'd0,  3'd0, 32'hFFFF_FFFF, 32'h0000_000F},  // R2
    {5'd2,  3'd0, 32'hFFFF_FFFF, 32'h3FFF_FFFF},  // R3
    {5'd3,  3'd0, 32'hC000_1234, 32'h0000_1234},  // R3
    {5'd4,  3'd0, 32'hFFFF_FFFF, 32'hA5FF_FFF0},  // R4
    {5'd5,  3'd0, 32'hFFFF_FFFF, 32'h01FF_E000},  // R5
    {5'd6,  3'd0, 32'hFFFF_FFF5, 32'h0000_0005},  // R5
    {5'd10, 3'd0, 32'h1234_5FFF, 32'h1234_50FF},  // R5
    {5'd12, 3'd0, 32'hFFFF_FFE9, 32'hFA78_FF01},  // R6
    {5'd13, 3'd0, 32'hFFFF_FFFF, 32'h00C0_0300},  // R7
    {5'd17, 3'd0, 32'h1234_5678, 32'h0123_4567},  // R12
    {5'd16, 3'd1, 32'h0000_0000, 32'h1E19_0C8A}   // R1
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] r, input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    rnum = r; sel = s; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rdr(input logic [4:0] r, input logic [2:0] s, output logic [31:0] d);
    @(negedge clk);
    rnum = r; sel = s; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    logic [31:0] v;
    do_reset();
    // reset state
    chk("R9 reset irq", {31'b0, irq}, 32'h0);
    chk("R8 reset rsvd", {31'b0, rsvd}, 32'h0);
    rdr(5'd4, 3'd0, v); chk("R4 reset context", v, 32'hA500_0000);
    rdr(5'd12, 3'd0, v); chk("R6 reset status", v, 32'h0);

    // table walk: write then read back
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][71:67], VEC[i][66:64], VEC[i][63:32]);
      rdr(VEC[i][71:67], VEC[i][66:64], v);
      chk($sformatf("R1-R12 vector %0d", i), v, VEC[i][31:0]);
    end
    rdr(5'd16, 3'd0, v); chk("R1 config word 0", v, 32'h8000_0482);
    // R13: output holds without a read
    @(negedge clk); @(negedge clk);
    chk("R13 read data held", rdata, 32'h8000_0482);

    do_reset();
    // R8: reserved write to status does nothing, pulses flag once
    wr(5'd12, 3'd1, 32'hFFFF_FFFF);
    chk("R8 rsvd pulse after write", {31'b0, rsvd}, 32'h1);
    @(negedge clk);
    chk("R8 rsvd drops", {31'b0, rsvd}, 32'h0);
    rdr(5'd12, 3'd0, v); chk("R8 status untouched", v, 32'h0);
    rdr(5'd2, 3'd3, v);
    chk("R8 rsvd read zero", v, 32'h0);
    chk("R8 rsvd pulse after read", {31'b0, rsvd}, 32'h1);
    rdr(5'd28, 3'd2, v);
    chk("R1 reg28 nonzero sel not reserved", {31'b0, rsvd}, 32'h0);

    // R7: hardware lines into cause
    hw = 6'b000001;
    @(negedge clk); @(negedge clk);
    rdr(5'd13, 3'd0, v); chk("R7 hw line in cause", v, 32'h0000_0400);

    // R9 blocked cases
    wr(5'd12, 3'd0, 32'h0000_0403);
    chk("R9 exl blocks", {31'b0, irq}, 32'h0);
    rdr(5'd12, 3'd0, v); chk("R6 exl flag readback", v, 32'h0000_0403);
    wr(5'd12, 3'd0, 32'h0000_0400);
    dbg = 1'b1;
    wr(5'd12, 3'd0, 32'h0000_0401);
    chk("R9 debug blocks", {31'b0, irq}, 32'h0);
    wr(5'd12, 3'd0, 32'h0000_0400);
    dbg = 1'b0;
    wr(5'd12, 3'd0, 32'h0000_0801);
    chk("R9 mask miss blocks", {31'b0, irq}, 32'h0);
    wr(5'd12, 3'd0, 32'h0000_0400);
    wr(5'd12, 3'd0, 32'h0000_0401);
    chk("R9 raise", {31'b0, irq}, 32'h1);
    wr(5'd12, 3'd0, 32'h0000_0401);
    chk("R10 stays without clear", {31'b0, irq}, 32'h1);
    wr(5'd12, 3'd0, 32'h0000_0400);
    chk("R10 withdraw", {31'b0, irq}, 32'h0);

    // R11: software bit raise
    hw = '0;
    @(negedge clk); @(negedge clk);
    wr(5'd12, 3'd0, 32'h0000_0101);
    chk("R11 no source yet", {31'b0, irq}, 32'h0);
    wr(5'd13, 3'd0, 32'h0000_0100);
    chk("R11 sw raise", {31'b0, irq}, 32'h1);
    rdr(5'd13, 3'd0, v); chk("R7 sw bit stored", v, 32'h0000_0100);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule